// File: doc/BRIEF.md
# Pin-Edge, Port-Change and Timer Interrupt Controller

This controller sits next to a small 8-bit processor core and collects three interrupt sources. The first is a dedicated external pin whose active edge, rising or falling, software selects. The second is a group of four port pins, where any change of state counts as an event. The third is a one-cycle overflow pulse from an on-chip timer. Each source has a sticky flag and a local enable. One global enable gates the request line to the core. The controller drives the request, supplies the fixed interrupt vector, and manages the global enable across an interrupt.

When the core accepts an interrupt it pulses `irq_ack`, which clears the global enable so that no second interrupt can nest. The return-from-interrupt strobe `irq_ret` sets the global enable again. Only software can clear the flags, so any flag left set and enabled raises the request again straight after the return. The pin and port inputs are asynchronous and pass through a two-flop synchronizer. The port-change detector compares the synchronized pins against a snapshot that is taken each time software reads the port register.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0, `irq_req` is low, and the edge select reads 0, which selects the falling edge.
- R2: With the edge-select bit (address 1, bit 0) at 1, a rising edge on `ext_pin` sets the pin flag (address 0, bit 2). The flag is readable three clock edges after the first edge that samples the new level, and a falling edge leaves it clear.
- R3: With the edge-select bit at 0, a falling edge on `ext_pin` sets the pin flag and a rising edge leaves it clear.
- R4: The port-change flag (address 0, bit 0) is set whenever the synchronized `port_pins` differ from the snapshot. A read of address 2 returns the synchronized pins in bits 3:0 and reloads the snapshot from them.
- R5: A high cycle on `tmr_ovf` sets the timer flag (address 0, bit 1) at that clock edge.
- R6: Flags are set by their events even while their local enable and the global enable are clear.
- R7: `irq_req` is high exactly when the global enable (address 0, bit 7) is set and at least one flag is set together with its enable. The enable bits sit at address 0: bit 6 for the pin, bit 5 for the timer, bit 4 for the port.
- R8: A pulse on `irq_ack` clears the global enable, and it wins over `irq_ret` and over a write. A pulse on `irq_ret` sets it again, so a flag that is still pending re-raises `irq_req` on the next cycle.
- R9: Flags clear only through a software write to address 0, and a hardware event in the same cycle as a clearing write keeps the flag set.
- R10: `irq_vector` always reads 0x04.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 1 | External interrupt pin, asynchronous |
| port_pins | input | 4 | Port pins watched for change, asynchronous |
| tmr_ovf | input | 1 | Timer overflow pulse, synchronous |
| reg_addr | input | 2 | Register address: 0 control, 1 edge select, 2 port |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; a read of address 2 reloads the snapshot |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq_ack | input | 1 | Core has taken the interrupt |
| irq_ret | input | 1 | Core executed return-from-interrupt |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vector | output | 8 | Interrupt vector address |

## Verification
The bench drives an edge of the wrong polarity for the current select setting. A design with the polarity inverted, or one that fires on both edges, would set the pin flag there. The bench writes a flag clear in the same cycle as a timer pulse. A design that lets the write win would lose the event. The bench pulses `irq_ret` while a flag is still pending. A design that clears flags on entry, or that forgets to restore the global enable, would leave `irq_req` low. The bench also checks that a port read reloads the snapshot. Without that reload, the port flag would come back straight after software clears it.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int DATA_W  = 8;
    localparam int NSRC    = 3;
    localparam int SRC_CHG = 0;
    localparam int SRC_TMR = 1;
    localparam int SRC_EXT = 2;

    localparam int CTRL_GIE_BIT = 7;
    localparam int CTRL_EN_LSB  = 4;
    localparam int CTRL_FLG_LSB = 0;
    localparam int CFG_RISE_BIT = 0;

    typedef enum logic [1:0] {
        ADR_CTRL = 2'd0,
        ADR_CFG  = 2'd1,
        ADR_PORT = 2'd2,
        ADR_NONE = 2'd3
    } reg_adr_e;

    typedef struct packed {
        logic            gie;
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] flg;
        logic            rise;
    } regs_st_t;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= '0;
                else        stg_q[g] <= stg_d[g];
            end
        end
    endgenerate

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/irqc_detect.sv
module irqc_detect #(
    parameter int PORT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_s,
    input  logic [PORT_W-1:0] port_s,
    input  logic              edge_rise,
    input  logic              snap,
    output logic              ext_ev,
    output logic              chg_ev
);
    typedef struct packed {
        logic              ext_prev;
        logic [PORT_W-1:0] latch;
    } det_st_t;

    det_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.ext_prev = ext_s;
        if (snap) st_d.latch = port_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ext_ev = edge_rise ? (ext_s & ~st_q.ext_prev) : (~ext_s & st_q.ext_prev);
    assign chg_ev = |(port_s ^ st_q.latch);

    // R4: after a snapshot, a steady port raises no change event
    a_r4_snap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        snap && $stable(port_s) |=> (!chg_ev || (port_s != $past(port_s))));
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_cfg,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NSRC-1:0]   hw_ev,
    input  logic              irq_ack,
    input  logic              irq_ret,
    output logic              gie,
    output logic [NSRC-1:0]   en,
    output logic [NSRC-1:0]   flg,
    output logic              rise,
    output logic              irq_req
);
    regs_st_t st_d, st_q;
    logic     spare_unused;

    assign spare_unused = ^{wdata[3], wdata[DATA_W-1:1]};

    always_comb begin
        st_d = st_q;
        if (wr_ctrl) begin
            st_d.gie = wdata[CTRL_GIE_BIT];
            st_d.en  = wdata[CTRL_EN_LSB +: NSRC];
            st_d.flg = wdata[CTRL_FLG_LSB +: NSRC];
        end
        st_d.flg = st_d.flg | hw_ev;
        if (wr_cfg)  st_d.rise = wdata[CFG_RISE_BIT];
        if (irq_ret) st_d.gie  = 1'b1;
        if (irq_ack) st_d.gie  = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gie     = st_q.gie;
    assign en      = st_q.en;
    assign flg     = st_q.flg;
    assign rise    = st_q.rise;
    assign irq_req = st_q.gie & |(st_q.en & st_q.flg);

    // R8: acceptance clears the global enable
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !gie);
    // R8: return restores it
    a_r8_ret_sets: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ret && !irq_ack |=> gie);
    // R8: no request while an interrupt is in service
    a_r8_no_nest: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack && !wr_ctrl |=> !irq_req);

    generate
        for (genvar s = 0; s < NSRC; s++) begin : g_flag_chk
            // R9: a flag holds until software writes
            a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
                flg[s] && !wr_ctrl |=> flg[s]);
            // R9: hardware set beats a clearing write
            a_r9_hw_wins: assert property (@(posedge clk) disable iff (!rst_n)
                hw_ev[s] |=> flg[s]);
        end
    endgenerate
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int              PORT_W      = 4,
    parameter int              SYNC_STAGES = 2,
    parameter logic [DATA_W-1:0] INT_VECTOR = 8'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_pin,
    input  logic [PORT_W-1:0] port_pins,
    input  logic              tmr_ovf,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              irq_ack,
    input  logic              irq_ret,
    output logic              irq_req,
    output logic [DATA_W-1:0] irq_vector
);
    localparam int SYNC_W = PORT_W + 1;

    logic [SYNC_W-1:0] sync_out;
    logic              ext_s;
    logic [PORT_W-1:0] port_s;
    logic              ext_ev, chg_ev;
    logic [NSRC-1:0]   hw_ev;
    logic              gie, rise;
    logic [NSRC-1:0]   en, flg;
    logic              wr_ctrl, wr_cfg, snap;

    assign wr_ctrl = reg_wr && (reg_addr == ADR_CTRL);
    assign wr_cfg  = reg_wr && (reg_addr == ADR_CFG);
    assign snap    = reg_rd && (reg_addr == ADR_PORT);

    irqc_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ext_pin, port_pins}),
        .dout (sync_out)
    );

    assign ext_s  = sync_out[SYNC_W-1];
    assign port_s = sync_out[PORT_W-1:0];

    irqc_detect #(.PORT_W(PORT_W)) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_s    (ext_s),
        .port_s   (port_s),
        .edge_rise(rise),
        .snap     (snap),
        .ext_ev   (ext_ev),
        .chg_ev   (chg_ev)
    );

    always_comb begin
        hw_ev          = '0;
        hw_ev[SRC_EXT] = ext_ev;
        hw_ev[SRC_TMR] = tmr_ovf;
        hw_ev[SRC_CHG] = chg_ev;
    end

    irqc_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_ctrl(wr_ctrl),
        .wr_cfg (wr_cfg),
        .wdata  (reg_wdata),
        .hw_ev  (hw_ev),
        .irq_ack(irq_ack),
        .irq_ret(irq_ret),
        .gie    (gie),
        .en     (en),
        .flg    (flg),
        .rise   (rise),
        .irq_req(irq_req)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_adr_e'(reg_addr))
            ADR_CTRL: begin
                reg_rdata[CTRL_GIE_BIT]          = gie;
                reg_rdata[CTRL_EN_LSB +: NSRC]   = en;
                reg_rdata[CTRL_FLG_LSB +: NSRC]  = flg;
            end
            ADR_CFG:  reg_rdata[CFG_RISE_BIT] = rise;
            ADR_PORT: reg_rdata[PORT_W-1:0]   = port_s;
            ADR_NONE: reg_rdata = '0;
        endcase
    end

    assign irq_vector = INT_VECTOR;

    // R7: a request always has the global enable behind it
    a_r7_req_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> reg_rdata[CTRL_GIE_BIT] || reg_addr != ADR_CTRL);
endmodule

// File: tb/tb_pin_irq_ctrl.sv
module tb_pin_irq_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_pin = 1'b0;
    logic [3:0] port_pins = 4'h0;
    logic       tmr_ovf = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_ack = 1'b0;
    logic       irq_ret = 1'b0;
    logic       irq_req;
    logic [7:0] irq_vector;

    int errors = 0;
    int checks = 0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    pin_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .port_pins(port_pins),
        .tmr_ovf(tmr_ovf), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_ack(irq_ack),
        .irq_ret(irq_ret), .irq_req(irq_req), .irq_vector(irq_vector)
    );

    // behavioural reference
    bit       m_gie, m_rise;
    bit [2:0] m_en, m_flg;
    bit [3:0] m_latch;
    bit       eh[$];
    bit [3:0] ph[$];

    task automatic model_clear();
        m_gie = 0; m_rise = 0; m_en = 0; m_flg = 0; m_latch = 0;
        eh = {};
        ph = {};
        for (int i = 0; i < 4; i++) begin
            eh.push_back(1'b0);
            ph.push_back(4'h0);
        end
    endtask

    initial model_clear();

    always @(posedge clk) begin
        if (!rst_n) begin
            model_clear();
        end else begin
            bit ev_ext, ev_chg;
            bit [2:0] hw;
            bit wrc;
            eh.push_front(ext_pin); void'(eh.pop_back());
            ph.push_front(port_pins); void'(ph.pop_back());
            ev_ext = m_rise ? (eh[2] && !eh[3]) : (!eh[2] && eh[3]);
            ev_chg = (ph[2] != m_latch);
            if (reg_rd && reg_addr == 2'd2) m_latch = ph[2];
            hw = {ev_ext, tmr_ovf, ev_chg};
            wrc = reg_wr && reg_addr == 2'd0;
            if (wrc) begin
                m_en  = reg_wdata[6:4];
                m_flg = reg_wdata[2:0];
            end
            m_flg = m_flg | hw;
            if (irq_ack)      m_gie = 0;
            else if (irq_ret) m_gie = 1;
            else if (wrc)     m_gie = reg_wdata[7];
            if (reg_wr && reg_addr == 2'd1) m_rise = reg_wdata[0];
        end
    end

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            logic [7:0] exp_rd;
            case (reg_addr)
                2'd0:    exp_rd = {m_gie, m_en, 1'b0, m_flg};
                2'd1:    exp_rd = {7'b0, m_rise};
                2'd2:    exp_rd = {4'b0, ph[1]};
                default: exp_rd = 8'h00;
            endcase
            check({cur_req, " rdata"}, reg_rdata, exp_rd);
            check("R7 irq_req", {7'b0, irq_req}, {7'b0, m_gie && |(m_en & m_flg)});
            check("R10 vector", irq_vector, 8'h04);
        end
    end

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        step();
        reg_wr = 1'b0; reg_addr = 2'd0;
    endtask

    task automatic rd_port();
        reg_addr = 2'd2; reg_rd = 1'b1;
        step();
        reg_rd = 1'b0; reg_addr = 2'd0;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        step(3);
        #(CLK_PERIOD/2);
        check("R1 ctrl reset", reg_rdata, 8'h00);
        check("R1 req reset", {7'b0, irq_req}, 8'h00);
        rst_n = 1'b1;
        step();
        reg_addr = 2'd1; #2;
        check("R1 edge select reset", reg_rdata, 8'h00);
        reg_addr = 2'd0;

        cur_req = "R2";
        wr(2'd1, 8'h01);
        ext_pin = 1'b1; step(4);
        check("R2 R6 rising sets pin flag", reg_rdata & 8'h04, 8'h04);
        wr(2'd0, 8'h00);
        ext_pin = 1'b0; step(4);
        check("R2 falling ignored", reg_rdata & 8'h04, 8'h00);

        cur_req = "R3";
        wr(2'd1, 8'h00);
        ext_pin = 1'b1; step(4);
        check("R3 rising ignored", reg_rdata & 8'h04, 8'h00);
        ext_pin = 1'b0; step(4);
        check("R3 falling sets pin flag", reg_rdata & 8'h04, 8'h04);
        wr(2'd0, 8'h00);

        cur_req = "R5";
        tmr_ovf = 1'b1; step(); tmr_ovf = 1'b0;
        check("R5 R6 timer flag", reg_rdata & 8'h02, 8'h02);
        wr(2'd0, 8'h00);

        cur_req = "R4";
        port_pins = 4'b0100; step(3);
        check("R4 change sets flag", reg_rdata & 8'h01, 8'h01);
        rd_port();
        wr(2'd0, 8'h00); step(2);
        check("R4 snapshot quiets flag", reg_rdata & 8'h01, 8'h00);
        reg_addr = 2'd2; #2;
        check("R4 port readback", reg_rdata, 8'h04);
        reg_addr = 2'd0;
        port_pins = 4'b0101; step(3);
        check("R4 second pin change", reg_rdata & 8'h01, 8'h01);
        rd_port(); wr(2'd0, 8'h00); step();

        cur_req = "R9";
        tmr_ovf = 1'b1; wr(2'd0, 8'h00); tmr_ovf = 1'b0;
        check("R9 hw set beats clear", reg_rdata & 8'h02, 8'h02);
        step(5);
        check("R9 flag sticky", reg_rdata & 8'h02, 8'h02);

        cur_req = "R7";
        wr(2'd0, 8'hA2);
        check("R7 request raised", {7'b0, irq_req}, 8'h01);
        wr(2'd0, 8'h82);
        check("R7 enable off drops request", {7'b0, irq_req}, 8'h00);
        wr(2'd0, 8'h22);
        check("R7 gie off drops request", {7'b0, irq_req}, 8'h00);

        cur_req = "R8";
        wr(2'd0, 8'hA2);
        irq_ack = 1'b1; step(); irq_ack = 1'b0;
        check("R8 ack clears gie", reg_rdata & 8'h80, 8'h00);
        check("R8 no request in service", {7'b0, irq_req}, 8'h00);
        step(3);
        irq_ret = 1'b1; step(); irq_ret = 1'b0;
        check("R8 ret re-raises pending", {7'b0, irq_req}, 8'h01);
        irq_ack = 1'b1; irq_ret = 1'b1; step(); irq_ack = 1'b0; irq_ret = 1'b0;
        check("R8 ack wins over ret", reg_rdata & 8'h80, 8'h00);
        wr(2'd0, 8'h20);
        irq_ret = 1'b1; step(); irq_ret = 1'b0;
        check("R8 ret with no flag", {7'b0, irq_req}, 8'h00);
        step(3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule